// File: doc/BRIEF.md
# Extended Register-Form Bit and MAC Unit

This is a purely combinational execution unit for four extended register-to-register operations of a 32-bit core: multiply-accumulate into the destination, extraction of a right-aligned bit field, reversal of byte order and counting of leading zero bits. The decoder passes it the opcode, the function code and three operand values: the two source registers and the current value of the destination register. The unit returns a single 32-bit result in the same cycle.

The unit answers only when the opcode is the register-form opcode (0x01) and the function code is one of its four. In every other case it drives zero, so its output can be ORed into a wider result bus. It produces no flags, and it has no storage or pipeline stage.

Top module: `xop_unit`

## Requirements
- R1: With opcode 0x01 and function 0x006 (MAC), `res` equals `rd_old + rs_a * rs_b`.
- R2: The MAC result keeps only the low 32 bits of the full sum. Carries and upper product bits are lost.
- R3: With opcode 0x01 and function 0x00D (field extract), `rs_b[4:0]` gives the start bit and `rs_b[10:5]` gives the length. `res` holds `rs_a[start +: length]` in its low bits, and every bit above the field is zero.
- R4: When start plus length passes bit 31, the extract returns only the bits of `rs_a` that exist, with zeros above them.
- R5: An extract length of 0 returns zero. A length field above 32 behaves as a length of 32.
- R6: With opcode 0x01 and function 0x00E (byte swap), byte k of `res` equals byte 3-k of `rs_a`.
- R7: With opcode 0x01 and function 0x00F (leading zeros), `res` is the count of zero bits above the highest set bit of `rs_a`.
- R8: The leading-zero count of a zero operand is 32.
- R9: Any other opcode, or any other function code under opcode 0x01, gives `res` equal to zero.
- R10: Byte swap and leading zeros ignore `rs_b` and `rd_old`. The extract ignores `rd_old` and `rs_b[31:11]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode of the instruction |
| funct | input | 10 | Function code of the register form |
| rs_a | input | 32 | First source register value |
| rs_b | input | 32 | Second source register value, or the packed start and length |
| rd_old | input | 32 | Current destination value, read by MAC |
| res | output | 32 | Operation result, zero when not selected |

## Verification
Two functions can act in the same cycle when the operation reads the destination register and the destination is also a source. MAC then sees one register on both `rd_old` and a source port. The bench applies equal values on those ports and checks the sum. It also checks the case where the operation switches from MAC to extract while `rd_old` holds a large value, and confirms that the old destination value no longer reaches the output. Each result is compared with a value worked out from the requirements for that operand pattern.

// File: rtl/xop_unit.sv
module xop_unit #(
  parameter int W = 32
) (
  input  logic [6:0]   opcode,
  input  logic [9:0]   funct,
  input  logic [W-1:0] rs_a,
  input  logic [W-1:0] rs_b,
  input  logic [W-1:0] rd_old,
  output logic [W-1:0] res
);
  localparam int SW = $clog2(W);
  localparam int LW = SW + 1;
  localparam int NB = W / 8;
  localparam logic [6:0] OP_REG = 7'h01;
  localparam logic [9:0] FN_MAC = 10'h006;
  localparam logic [9:0] FN_EXT = 10'h00D;
  localparam logic [9:0] FN_SWP = 10'h00E;
  localparam logic [9:0] FN_LZC = 10'h00F;

  logic [W-1:0] mac_r, ext_r, swp_r, lzc_r, ext_mask;
  logic [SW-1:0] ext_pos;
  logic [LW-1:0] ext_len;

  assign mac_r = W'(rd_old + rs_a * rs_b);

  assign ext_pos = rs_b[SW-1:0];
  assign ext_len = rs_b[SW +: LW];
  assign ext_mask = (ext_len >= LW'(W)) ? '1 : ((W'(1) << ext_len) - W'(1));
  assign ext_r = (rs_a >> ext_pos) & ext_mask;

  for (genvar k = 0; k < NB; k++) begin : g_swap
    assign swp_r[8*k +: 8] = rs_a[8*(NB-1-k) +: 8];
  end

  always_comb begin
    lzc_r = W'(W);
    for (int i = 0; i < W; i++)
      if (rs_a[i]) lzc_r = W'(W - 1 - i);
  end

  always_comb begin
    res = '0;
    if (opcode == OP_REG) begin
      case (funct)
        FN_MAC:  res = mac_r;
        FN_EXT:  res = ext_r;
        FN_SWP:  res = swp_r;
        FN_LZC:  res = lzc_r;
        default: res = '0;
      endcase
    end
  end
endmodule

module xop_unit_chk #(
  parameter int W = 32
) (
  input logic [6:0]   opcode,
  input logic [9:0]   funct,
  input logic [W-1:0] rs_a,
  input logic [W-1:0] rs_b,
  input logic [W-1:0] rd_old,
  input logic [W-1:0] res
);
  localparam int SW = $clog2(W);
  logic known;
  assign known = !$isunknown({opcode, funct, rs_a, rs_b, rd_old});

  always_comb begin
    if (known) begin
      a_r9_idle_zero: assert (opcode == 7'h01 || res == '0);
      if (opcode == 7'h01 && funct == 10'h006 && rs_a == '0)
        a_r1_mac_zero_prod: assert (res == rd_old);
      if (opcode == 7'h01 && funct == 10'h00D && rs_b[SW +: SW+1] < (SW+1)'(W))
        a_r3_ext_upper_clear: assert ((res >> rs_b[SW +: SW+1]) == '0);
      if (opcode == 7'h01 && funct == 10'h00E)
        a_r6_swap_popcount: assert ($countones(res) == $countones(rs_a));
      if (opcode == 7'h01 && funct == 10'h00F && rs_a == '0)
        a_r8_lzc_all_zero: assert (res == W);
      if (opcode == 7'h01 && funct == 10'h00F && rs_a != '0)
        a_r7_lzc_lead_bit: assert (res < W && rs_a[W-1-res] && (rs_a >> (W-res)) == '0);
    end
  end
endmodule

bind xop_unit xop_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_xop_unit.sv
module sim_xop_unit;
  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [6:0]  opcode;
  logic [9:0]  funct;
  logic [31:0] rs_a, rs_b, rd_old, res;
  int checks = 0, errors = 0;

  xop_unit u0 (.opcode(opcode), .funct(funct), .rs_a(rs_a), .rs_b(rs_b),
               .rd_old(rd_old), .res(res));

  localparam int NV = 18;
  // {funct, rs_a, rs_b, rd_old, expected}
  localparam logic [137:0] VEC [NV] = '{
    {10'h006, 32'h00000003, 32'h00000005, 32'h0000000A, 32'h00000019}, // R1
    {10'h006, 32'h00010000, 32'h00010000, 32'h00000007, 32'h00000007}, // R2
    {10'h006, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'hFFFFFFFF}, // R2
    {10'h006, 32'h00000004, 32'h00000004, 32'h00000004, 32'h00000014}, // R1 aliased dest
    {10'h00D, 32'h12345678, 32'h00000108, 32'hFFFFFFFF, 32'h00000056}, // R3
    {10'h00D, 32'hDEADBEEF, 32'h00000184, 32'h00000000, 32'h00000BEE}, // R3
    {10'h00D, 32'hF0000000, 32'h0000011C, 32'h00000000, 32'h0000000F}, // R4
    {10'h00D, 32'hCAFEBABE, 32'h00000400, 32'h00000000, 32'hCAFEBABE}, // R5
    {10'h00D, 32'hFFFFFFFF, 32'h00000003, 32'h00000000, 32'h00000000}, // R5
    {10'h00D, 32'hABCD1234, 32'h00000510, 32'h00000000, 32'h0000ABCD}, // R5
    {10'h00D, 32'h12345678, 32'hFFFFF908, 32'h12345678, 32'h00000056}, // R10
    {10'h00E, 32'h11223344, 32'hFFFFFFFF, 32'h00000055, 32'h44332211}, // R6 R10
    {10'h00E, 32'h000000FF, 32'h00000000, 32'h00000000, 32'hFF000000}, // R6
    {10'h00F, 32'h00010000, 32'h12345678, 32'h00000009, 32'h0000000F}, // R7 R10
    {10'h00F, 32'h80000000, 32'h00000000, 32'h00000000, 32'h00000000}, // R7
    {10'h00F, 32'h00000001, 32'h00000000, 32'h00000000, 32'h0000001F}, // R7
    {10'h00F, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000020}, // R8
    {10'h001, 32'h00000001, 32'h00000001, 32'h00000001, 32'h00000000}  // R9
  };

  task automatic check(input string req, input logic [31:0] exp);
    @(negedge clk);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s: res=%h expected=%h", req, res, exp);
    end
  endtask

  task automatic drive(input logic [6:0] o, input logic [9:0] f,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
    @(posedge clk);
    opcode = o; funct = f; rs_a = a; rs_b = b; rd_old = d;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: res=%h expected=done", res);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    opcode = '0; funct = '0; rs_a = '0; rs_b = '0; rd_old = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    check("R9 reset idle", 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(7'h01, VEC[i][137:128], VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("vector %0d (R1-R10 table)", i), VEC[i][31:0]);
    end

    drive(7'h02, 10'h006, 32'h3, 32'h5, 32'h7);
    check("R9 other opcode", 32'h0);
    drive(7'h01, 10'h010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R9 unused funct", 32'h0);
    drive(7'h01, 10'h006, 32'h2, 32'h3, 32'hFFFFFFF0);
    check("R1 mac before switch", 32'hFFFFFFF6);
    drive(7'h01, 10'h00D, 32'h000000F0, 32'h00000084, 32'hFFFFFFF0);
    check("R10 extract drops rd_old", 32'h0000000F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule